// File: doc/BRIEF.md
# Bidirectional LCD Scan Driver Core

This block is the digital part of a row (scan) driver for a dot-matrix LCD. It contains two separate 80-stage shift chains that can be cascaded. Each chain owns one half of the 160 driver positions. The controller shifts a scan token through the chains. Every stage then selects one of four bias levels for its driver position. The level depends on the stored bit, an AC-inversion phase input and an active-low blanking input. The analog levels themselves are generated outside the block. Here each choice is only a 2-bit code.

A single direction input reverses both chains while the block runs. When the direction changes, the serial input and serial output ends of each chain swap places. Each end therefore has a separate input, an output and an output-enable, so that a pad ring can build a bidirectional pin from them. Shifting happens on the falling edge of the shift clock. The asynchronous reset is released in step with that edge.

Top module: `lcd_scan_driver`

## Requirements
- R1: There are two chains. Chain 0 drives positions 0..79 and chain 1 drives positions 80..159. Data fed into one chain never appears in the other.
- R2: With `dir_rev`=0, each falling edge moves every bit one position toward the higher index, and the low-end input enters the lowest position. With `dir_rev`=1 both chains move toward the lower index, and the high-end input enters the highest position.
- R3: `lo_oe[c]` is 1 exactly when `dir_rev`=1, and `hi_oe[c]` is 1 exactly when `dir_rev`=0.
- R4: A bit presented at an input end before falling edge k is visible on the opposite end output after edge k+79 (80 edges in total). Before that edge the output does not show it.
- R5: Rising edges of `shift_clk` leave the chain contents unchanged.
- R6: With `blank_n`=1, the code of position p sits at `lvl_sel[2p+1:2p]`. A stored 1 gives 2'b11 when `ac_phase`=1 and 2'b00 when `ac_phase`=0. A stored 0 gives 2'b01 when `ac_phase`=1 and 2'b10 when `ac_phase`=0.
- R7: While `blank_n`=0, every position outputs 2'b00, whatever the chain contents and `ac_phase` are.
- R8: `rst_n` low clears both chains at once, without a clock. After `rst_n` rises, the first two falling edges do not shift and the third one does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock; the chains move on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_rev | input | 1 | Direction select for both chains |
| ac_phase | input | 1 | AC-inversion phase |
| blank_n | input | 1 | Active-low display blanking |
| lo_in | input | 2 | Serial input at the low end of each chain |
| hi_in | input | 2 | Serial input at the high end of each chain |
| lo_out | output | 2 | Low-end stage of each chain |
| hi_out | output | 2 | High-end stage of each chain |
| lo_oe | output | 2 | Drive enable for the low-end pins |
| hi_oe | output | 2 | Drive enable for the high-end pins |
| lvl_sel | output | 320 | 2-bit level code for each of the 160 positions |

## Verification
The shift properties assume that `dir_rev`, `lo_in` and `hi_in` are stable around each falling edge. They also wait one extra edge after the reset release before comparing one chain state with the next. The bench meets the stability assumption by changing every input 3 ns after a falling edge, never close to either edge, and it keeps serial inputs low while reset is asserted. The level properties look only at the first and last positions and treat blanking and the AC phase as quasi-static. The bench covers the remaining positions by comparing the whole 320-bit code vector against an arithmetic model.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    LV_V1  = 2'b00,
    LV_V2  = 2'b01,
    LV_V5  = 2'b10,
    LV_VEE = 2'b11
  } drive_lvl_e;

  // Blanking wins; otherwise the stored bit picks the pair, the phase the member
  function automatic drive_lvl_e pick_level(input logic scan, input logic ac,
                                            input logic blank_n);
    if (!blank_n) return LV_V1;
    if (scan)     return ac ? LV_VEE : LV_V1;
    return ac ? LV_V2 : LV_V5;
  endfunction

endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign rst_s = stg_q[STAGES-1];

endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int unsigned DEPTH = 80
) (
  input  logic             clk,
  input  logic             rst_s,
  input  logic             shift_en,
  input  logic             dir_rev,
  input  logic             ser_lo,
  input  logic             ser_hi,
  output logic [DEPTH-1:0] q,
  output logic             out_lo,
  output logic             out_hi,
  output logic             oe_lo,
  output logic             oe_hi
);

  logic [DEPTH-1:0] nxt;

  // Each stage takes its lower or upper neighbour, the ends take the pins
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic from_low;
    logic from_high;
    if (i == 0) begin : g_first
      assign from_low = ser_lo;
    end else begin : g_mid_lo
      assign from_low = q[i-1];
    end
    if (i == DEPTH - 1) begin : g_last
      assign from_high = ser_hi;
    end else begin : g_mid_hi
      assign from_high = q[i+1];
    end
    assign nxt[i] = dir_rev ? from_high : from_low;
  end

  always_ff @(negedge clk or negedge rst_s) begin
    if (!rst_s)        q <= '0;
    else if (shift_en) q <= nxt;
  end

  assign out_lo = q[0];
  assign out_hi = q[DEPTH-1];
  assign oe_lo  = dir_rev;
  assign oe_hi  = ~dir_rev;

  // One edge of settling after reset release before shift checks start
  logic armed;
  always_ff @(negedge clk or negedge rst_s) begin
    if (!rst_s) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_FWD_SHIFT: assert property (@(negedge clk) disable iff (!rst_s)
    (armed && shift_en && !dir_rev) |=> (q == {$past(q[DEPTH-2:0]), $past(ser_lo)})); // R2
  AST_REV_SHIFT: assert property (@(negedge clk) disable iff (!rst_s)
    (armed && shift_en && dir_rev) |=> (q == {$past(ser_hi), $past(q[DEPTH-1:1])})); // R2

endmodule

// File: rtl/level_map.sv
module level_map
  import lcd_scan_pkg::*;
#(
  parameter int unsigned POS = 160
) (
  input  logic [POS-1:0]   bits,
  input  logic             ac_phase,
  input  logic             blank_n,
  output logic [2*POS-1:0] lvl
);

  for (genvar p = 0; p < POS; p++) begin : g_pos
    drive_lvl_e sel;
    assign sel = pick_level(bits[p], ac_phase, blank_n);
    assign lvl[2*p +: 2] = sel;
  end

endmodule

// File: rtl/lcd_scan_driver.sv
module lcd_scan_driver #(
  parameter int unsigned SEG_LEN = 80,
  parameter int unsigned SEGS    = 2
) (
  input  logic                       shift_clk,
  input  logic                       rst_n,
  input  logic                       dir_rev,
  input  logic                       ac_phase,
  input  logic                       blank_n,
  input  logic [SEGS-1:0]            lo_in,
  input  logic [SEGS-1:0]            hi_in,
  output logic [SEGS-1:0]            lo_out,
  output logic [SEGS-1:0]            hi_out,
  output logic [SEGS-1:0]            lo_oe,
  output logic [SEGS-1:0]            hi_oe,
  output logic [2*SEG_LEN*SEGS-1:0]  lvl_sel
);

  localparam int unsigned NPOS = SEG_LEN * SEGS;

  logic            rst_s;
  logic            shift_en;
  logic [NPOS-1:0] scan_bits;

  assign shift_en = 1'b1;

  scan_rst_sync #(.STAGES(2)) u_rst (
    .clk   (shift_clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  for (genvar c = 0; c < SEGS; c++) begin : g_seg
    scan_chain #(.DEPTH(SEG_LEN)) u_chain (
      .clk      (shift_clk),
      .rst_s    (rst_s),
      .shift_en (shift_en),
      .dir_rev  (dir_rev),
      .ser_lo   (lo_in[c]),
      .ser_hi   (hi_in[c]),
      .q        (scan_bits[c*SEG_LEN +: SEG_LEN]),
      .out_lo   (lo_out[c]),
      .out_hi   (hi_out[c]),
      .oe_lo    (lo_oe[c]),
      .oe_hi    (hi_oe[c])
    );
  end

  level_map #(.POS(NPOS)) u_map (
    .bits     (scan_bits),
    .ac_phase (ac_phase),
    .blank_n  (blank_n),
    .lvl      (lvl_sel)
  );

  AST_BLANK_FORCE: assert property (@(negedge shift_clk) disable iff (!rst_n)
    !blank_n |-> (lvl_sel == '0)); // R7
  AST_AC_HIGH_ODD: assert property (@(negedge shift_clk) disable iff (!rst_n)
    (blank_n && ac_phase) |-> (lvl_sel[0] && lvl_sel[2*NPOS-2])); // R6
  AST_AC_LOW_EVEN: assert property (@(negedge shift_clk) disable iff (!rst_n)
    (blank_n && !ac_phase) |-> (!lvl_sel[0] && !lvl_sel[2*NPOS-2])); // R6
  AST_PAIR_FIRST: assert property (@(negedge shift_clk) disable iff (!rst_n)
    blank_n |-> ((lvl_sel[1] == lvl_sel[0]) == scan_bits[0])); // R6
  AST_PAIR_LAST: assert property (@(negedge shift_clk) disable iff (!rst_n)
    blank_n |-> ((lvl_sel[2*NPOS-1] == lvl_sel[2*NPOS-2]) == scan_bits[NPOS-1])); // R6

endmodule

// File: tb/sim_lcd_scan_driver.sv
module sim_lcd_scan_driver;

  localparam int L = 80;
  localparam int N = 160;

  logic         clk = 1'b0;
  logic         rst_n, dir_rev, ac_phase, blank_n;
  logic [1:0]   lo_in, hi_in, lo_out, hi_out, lo_oe, hi_oe;
  logic [2*N-1:0] lvl_sel;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  lcd_scan_driver u0 (
    .shift_clk(clk), .rst_n(rst_n), .dir_rev(dir_rev), .ac_phase(ac_phase),
    .blank_n(blank_n), .lo_in(lo_in), .hi_in(hi_in), .lo_out(lo_out),
    .hi_out(hi_out), .lo_oe(lo_oe), .hi_oe(hi_oe), .lvl_sel(lvl_sel)
  );

  function automatic logic [N-1:0] decode(input logic [2*N-1:0] v);
    logic [N-1:0] r;
    for (int p = 0; p < N; p++) r[p] = (v[2*p+1] == v[2*p]);
    return r;
  endfunction

  function automatic logic [2*N-1:0] model(input logic [N-1:0] b, input logic ac,
                                           input logic bl_n);
    logic [2*N-1:0] r;
    for (int p = 0; p < N; p++) begin
      if (!bl_n)    r[2*p +: 2] = 2'd0;
      else if (b[p]) r[2*p +: 2] = ac ? 2'd3 : 2'd0;
      else           r[2*p +: 2] = ac ? 2'd1 : 2'd2;
    end
    return r;
  endfunction

  task automatic check(input logic ok, input string req,
                       input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #3;
  endtask

  task automatic walk(input logic rev, input logic [1:0] feed);
    logic [N-1:0] exp;
    logic [N-1:0] snap;
    dir_rev = rev;
    if (rev) hi_in = feed; else lo_in = feed;
    step();
    lo_in = 2'b00; hi_in = 2'b00;
    check(lo_oe == {2{rev}} && hi_oe == {2{~rev}}, "R3", {lo_oe, hi_oe}, {{2{rev}}, {2{~rev}}});
    for (int k = 1; k <= L; k++) begin
      exp = '0;
      for (int c = 0; c < 2; c++)
        if (feed[c]) exp[c*L + (rev ? L - k : k - 1)] = 1'b1;
      check(decode(lvl_sel) == exp, rev ? "R2 R1 reverse" : "R2 R1 forward",
            decode(lvl_sel), exp);
      for (int c = 0; c < 2; c++) begin
        logic o;
        o = rev ? lo_out[c] : hi_out[c];
        check(o == (feed[c] && k == L), "R4", o, feed[c] && k == L);
      end
      if (k == 40) begin
        snap = decode(lvl_sel);
        @(posedge clk); #3;
        check(decode(lvl_sel) == snap, "R5", decode(lvl_sel), snap);
      end
      step();
    end
    check(decode(lvl_sel) == '0, "R2 drained", decode(lvl_sel), '0);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] pat;
    rst_n = 1'b0; dir_rev = 1'b0; ac_phase = 1'b0; blank_n = 1'b1;
    lo_in = 2'b00; hi_in = 2'b00;
    step(); step(); step();
    check(lvl_sel == model('0, 1'b0, 1'b1), "R8 reset", lvl_sel, model('0, 1'b0, 1'b1));
    rst_n = 1'b1;
    step(); step(); step();

    walk(1'b0, 2'b01);
    walk(1'b0, 2'b10);
    walk(1'b1, 2'b11);

    // Load a known pattern into both chains, forward direction
    pat = '0;
    for (int j = 0; j < L; j++) begin
      pat[j]     = (j % 3 == 0);
      pat[L + j] = (j % 4 == 1);
    end
    dir_rev = 1'b0;
    for (int e = 1; e <= L; e++) begin
      lo_in = {pat[L + L - e], pat[L - e]};
      step();
    end
    lo_in = 2'b00;
    for (int a = 0; a < 2; a++) begin
      for (int b = 0; b < 2; b++) begin
        ac_phase = a[0]; blank_n = b[0];
        #2;
        check(lvl_sel == model(pat, a[0], b[0]), b[0] ? "R6 mapping" : "R7 blanking",
              lvl_sel, model(pat, a[0], b[0]));
      end
    end

    // Asynchronous clear and synchronized release
    ac_phase = 1'b0; blank_n = 1'b1;
    #2;
    rst_n = 1'b0;
    #2;
    check(lvl_sel == model('0, 1'b0, 1'b1), "R8 async clear", lvl_sel, model('0, 1'b0, 1'b1));
    step();
    rst_n = 1'b1;
    lo_in = 2'b01;
    step(); step();
    check(decode(lvl_sel) == '0, "R8 held two edges", decode(lvl_sel), '0);
    step();
    lo_in = 2'b00;
    check(decode(lvl_sel) == 160'd1, "R8 first shift", decode(lvl_sel), 160'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule